// File: doc/BRIEF.md
# SPI Flash Direct-Access Command Sequencer

This block sits between an on-chip request stream and a single-lane SPI flash bus. Each request names a chip-select, a flash-window address, a width of one to four bytes and a direction. A 32-bit control word for that chip-select sets how the request is carried out. In the read, fast-read and write modes, one request becomes one complete framed flash command. The sequencer drives the chip-select low, shifts out the opcode, the address and any dummy bytes, moves the data bytes, and then drives the chip-select high again. In user mode the sequencer sends no header. The request's bytes go straight onto the wire, and the chip-select level comes from the control word.

Requests and responses use valid/ready handshakes. `req_ready` is high only while the sequencer is idle, so a request waits on the port until the previous transaction has finished and its response has been taken. The sequencer holds `rsp_valid` and its payload steady for as long as `rsp_ready` is low, and it accepts no new request during that time. The control words, the write-enable bits and the dummy byte are plain static inputs.

Top module: `sfl_cmd_seq`

## Requirements
- R1: After reset, with no chip-select in user mode: every `spi_cs_n` is high, `spi_sclk` is low, `busy` is low, `rsp_valid` is low and `req_ready` is high.
- R2: The control word's mode field is bits [1:0], with 0 = read, 1 = fast read, 2 = write and 3 = user. The opcode field is bits [23:16]. In read mode a read sends the opcode, then the address most significant byte first, then the data bytes. The chip-select goes low once before the first byte and high once after the last byte. An opcode of 0 in read mode goes out as 0x03.
- R3: When bit 13 of the control word is 1, the address phase is 4 bytes and includes address bits [31:24]. When bit 13 is 0, the address phase is bits [23:0] as 3 bytes.
- R4: Dummy bytes follow the address only in fast-read mode. Their number is ({bit14, bits[7:6]}) * 8, and every dummy byte equals `cfg_dummy`. The same field set in read mode adds no dummy bytes.
- R5: `req_size` is the byte count minus 1. During a read's data phase the sequencer sends 0x00 bytes. The byte received i-th goes to `rsp_rdata[8i+7:8i]`, and the unused upper lanes read as zero.
- R6: A write in read, fast-read or write mode is framed like a read. The opcode field is used as given. The data bytes go out lane 0 first, and only `req_size+1` lanes are sent.
- R7: In user mode, `spi_cs_n` of that chip-select follows control bit 2 (1 = deasserted). A user-mode access sends no opcode, address or dummy bytes and never moves the chip-select. Writes send their bytes, and reads send 0x00 bytes and return what comes back.
- R8: When `cfg_wr_en[cs]` is 0, a write to that chip-select produces no SPI activity. The sequencer answers the next cycle with `rsp_err` = 1.
- R9: The flash address is taken modulo 2^SEG_AW. Any nonzero address bit at or above SEG_AW sets `rsp_err`, and the transfer still runs with the reduced address.
- R10: From acceptance until the response is taken, `req_ready` stays low. `rsp_valid`, `rsp_rdata` and `rsp_err` hold while `rsp_ready` is low, and no SPI clock moves in that time. `req_ready` returns the cycle after the response handshake.
- R11: A read to a chip-select in write mode produces no SPI activity. It returns `rsp_err` = 1 and `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 32*NUM_CS | Control words, chip-select i at bits [32i+31:32i] |
| cfg_wr_en | input | NUM_CS | Per-chip-select flash write enable |
| cfg_dummy | input | 8 | Value sent in every dummy byte |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Target chip-select (CSW = clog2(NUM_CS), at least 1) |
| req_addr | input | 32 | Offset in the flash window |
| req_size | input | 2 | Byte count minus 1 |
| req_wdata | input | 32 | Write data, lane 0 first on the wire |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Read data, little-endian |
| rsp_err | output | 1 | Segment overflow, dropped write or invalid read |
| busy | output | 1 | Transaction in progress on the SPI side |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to flash, MSB first |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NUM_CS | Active-low chip-selects |

## Verification
Two things can fall in the same cycle: a held response and a fresh request. The bench keeps `rsp_ready` low for several cycles while a second request sits valid on the port. During that time it checks three things: the first response stays unchanged, `req_ready` stays low, and the flash model sees no extra clock edges. The bench then releases the response and expects the second request to be taken and framed on its own. A second overlap is a write that is both disabled and beyond the segment. For that case the bench expects the drop to win, with no SPI activity and a single error response.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_FAST  = 2'd1,
    MD_WRITE = 2'd2,
    MD_USER  = 2'd3
  } sfl_mode_e;

  typedef enum logic [1:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA
  } sfl_phase_e;

  typedef struct packed {
    sfl_mode_e  mode;
    logic [7:0] opcode;
    logic       addr4;
    logic [5:0] ndummy;
    logic       stop;
  } sfl_ctrl_t;

  localparam int CTRL_W = 32;
  localparam logic [7:0] DEFAULT_RD_OPC = 8'h03;
endpackage

// File: rtl/sfl_ctrl_decode.sv
module sfl_ctrl_decode
  import sfl_pkg::*;
(
  input  logic [CTRL_W-1:0] word,
  output sfl_ctrl_t         fld
);
  sfl_mode_e md;
  assign md = sfl_mode_e'(word[1:0]);

  always_comb begin
    fld.mode   = md;
    fld.opcode = (md == MD_READ && word[23:16] == 8'h00) ? DEFAULT_RD_OPC : word[23:16];
    fld.addr4  = word[13];
    fld.ndummy = (md == MD_FAST) ? {word[14], word[7:6], 3'b000} : 6'd0;
    fld.stop   = word[2];
  end
endmodule

// File: rtl/sfl_byte_shift.sv
module sfl_byte_shift #(
  parameter int HALF_DIV = 1,
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  logic          act;
  logic [2:0]    bitn;
  logic [7:0]    sreg;
  logic [DW-1:0] div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; sclk <= 1'b0; bitn <= '0; sreg <= '0;
      rx_byte <= '0; div <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !act) begin
        act <= 1'b1; sreg <= tx_byte; bitn <= '0; div <= '0; sclk <= 1'b0;
      end else if (act) begin
        if (div == DW'(HALF_DIV - 1)) begin
          div <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sreg <= {sreg[6:0], 1'b0};
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end

  assign mosi = sreg[7];
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
#(
  parameter int CSW    = 1,
  parameter int SEG_AW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [CSW-1:0]  req_cs,
  input  logic [31:0]     req_addr,
  input  logic [1:0]      req_size,
  input  logic [31:0]     req_wdata,
  input  sfl_mode_e       sel_mode,
  input  logic [7:0]      sel_opcode,
  input  logic            sel_addr4,
  input  logic [5:0]      sel_ndummy,
  input  logic            sel_wen,
  input  logic [7:0]      dummy_byte,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [31:0]     rsp_rdata,
  output logic            rsp_err,
  output logic            busy,
  output logic            cs_act,
  output logic [CSW-1:0]  act_cs,
  output logic            sh_start,
  output logic [7:0]      sh_tx,
  input  logic            sh_done,
  input  logic [7:0]      sh_rx
);
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_REL, ST_RESP} st_e;
  st_e        st;
  sfl_phase_e ph;
  logic [5:0] cnt;
  logic       wr_r, user_r, addr4_r;
  logic [1:0] size_r;
  logic [31:0] addr_r, wd_r, rd_r;
  logic [7:0] opc_r;
  logic [5:0] ndum_r;
  logic       err_r;
  logic       seg_err;
  logic [31:0] addr_red;

  assign seg_err  = |(req_addr >> SEG_AW);
  assign addr_red = req_addr & ((32'd1 << SEG_AW) - 32'd1);

  always_comb begin
    case (ph)
      PH_OPC:   sh_tx = opc_r;
      PH_ADDR:  sh_tx = addr_r[{cnt[1:0], 3'b000} +: 8];
      PH_DUMMY: sh_tx = dummy_byte;
      default:  sh_tx = wr_r ? wd_r[{cnt[1:0], 3'b000} +: 8] : 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_OPC; cnt <= '0; wr_r <= 1'b0; user_r <= 1'b0;
      addr4_r <= 1'b0; size_r <= '0; addr_r <= '0; wd_r <= '0; rd_r <= '0;
      opc_r <= '0; ndum_r <= '0; err_r <= 1'b0; cs_act <= 1'b0; act_cs <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          wr_r <= req_write; size_r <= req_size; addr_r <= addr_red;
          wd_r <= req_wdata; opc_r <= sel_opcode; addr4_r <= sel_addr4;
          ndum_r <= sel_ndummy; act_cs <= req_cs; rd_r <= '0;
          err_r <= seg_err; user_r <= (sel_mode == MD_USER); cnt <= '0;
          if ((req_write && !sel_wen) || (!req_write && sel_mode == MD_WRITE)) begin
            err_r <= 1'b1;
            st    <= ST_RESP;
          end else if (sel_mode == MD_USER) begin
            ph <= PH_DATA;
            st <= ST_LOAD;
          end else begin
            ph     <= PH_OPC;
            cs_act <= 1'b1;
            st     <= ST_LOAD;
          end
        end
        ST_LOAD: st <= ST_WAIT;
        ST_WAIT: if (sh_done) begin
          st <= ST_LOAD;
          case (ph)
            PH_OPC: begin
              ph  <= PH_ADDR;
              cnt <= addr4_r ? 6'd3 : 6'd2;
            end
            PH_ADDR: if (cnt == 6'd0) begin
              if (ndum_r != 6'd0) begin
                ph <= PH_DUMMY; cnt <= ndum_r - 6'd1;
              end else begin
                ph <= PH_DATA; cnt <= '0;
              end
            end else cnt <= cnt - 6'd1;
            PH_DUMMY: if (cnt == 6'd0) begin
              ph <= PH_DATA; cnt <= '0;
            end else cnt <= cnt - 6'd1;
            default: begin
              if (!wr_r) rd_r[{cnt[1:0], 3'b000} +: 8] <= sh_rx;
              if (cnt[1:0] == size_r) begin
                cs_act <= 1'b0;
                st     <= user_r ? ST_RESP : ST_REL;
              end else cnt <= cnt + 6'd1;
            end
          endcase
        end
        ST_REL:  st <= ST_RESP;
        default: if (rsp_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rd_r;
  assign rsp_err   = err_r;
  assign busy      = (st == ST_LOAD) || (st == ST_WAIT) || (st == ST_REL);
  assign sh_start  = (st == ST_LOAD);
endmodule

// File: rtl/sfl_cmd_seq.sv
module sfl_cmd_seq
  import sfl_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int SEG_AW   = 24,
  parameter int HALF_DIV = 1,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CS*CTRL_W-1:0] cfg_ctrl,
  input  logic [NUM_CS-1:0]        cfg_wr_en,
  input  logic [7:0]               cfg_dummy,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [CSW-1:0]           req_cs,
  input  logic [31:0]              req_addr,
  input  logic [1:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  output logic                     busy,
  output logic                     spi_sclk,
  output logic                     spi_mosi,
  input  logic                     spi_miso,
  output logic [NUM_CS-1:0]        spi_cs_n
);
  sfl_ctrl_t      dec [NUM_CS];
  logic           cs_act;
  logic [CSW-1:0] act_cs;
  logic           sh_start, sh_done;
  logic [7:0]     sh_tx, sh_rx;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    sfl_ctrl_decode u_dec (
      .word (cfg_ctrl[i*CTRL_W +: CTRL_W]),
      .fld  (dec[i])
    );
    assign spi_cs_n[i] = (dec[i].mode == MD_USER) ? dec[i].stop
                                                  : !(cs_act && act_cs == CSW'(i));
  end

  sfl_seq #(.CSW(CSW), .SEG_AW(SEG_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .sel_mode   (dec[req_cs].mode),
    .sel_opcode (dec[req_cs].opcode),
    .sel_addr4  (dec[req_cs].addr4),
    .sel_ndummy (dec[req_cs].ndummy),
    .sel_wen    (cfg_wr_en[req_cs]),
    .dummy_byte (cfg_dummy),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .busy       (busy),
    .cs_act     (cs_act),
    .act_cs     (act_cs),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx)
  );

  sfl_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );
endmodule

// File: rtl/sfl_cmd_seq_chk.sv
module sfl_cmd_seq_chk #(
  parameter int NUM_CS = 2,
  parameter int CSW    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [CSW-1:0]    req_cs,
  input logic [NUM_CS-1:0] cfg_wr_en,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              busy,
  input logic              spi_sclk
);
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R10

  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready); // R10

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk); // R1

  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && !cfg_wr_en[req_cs] |=> rsp_valid && rsp_err && !busy); // R8
endmodule

bind sfl_cmd_seq sfl_cmd_seq_chk #(.NUM_CS(NUM_CS), .CSW(CSW)) u_chk (.*);

// File: tb/tb_sfl_cmd_seq.sv
module tb_sfl_cmd_seq;
  localparam int NUM_CS = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NUM_CS*32-1:0] cfg_ctrl = '0;
  logic [NUM_CS-1:0] cfg_wr_en = '0;
  logic [7:0] cfg_dummy = 8'hA5;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [0:0] req_cs = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_size = '0;
  logic req_ready, rsp_valid, rsp_err, busy, spi_sclk, spi_mosi, spi_miso;
  logic [31:0] rsp_rdata;
  logic [NUM_CS-1:0] spi_cs_n;

  sfl_cmd_seq dut (.*);

  int errors = 0, checks = 0;
  logic [7:0] cap [0:127];
  logic [7:0] exb [0:127];
  int ncap = 0, nexp = 0, bitc = 0, nfall = 0;
  logic [7:0] sh = 0;
  int falls [NUM_CS];
  int rises [NUM_CS];
  logic [NUM_CS-1:0] prev_cs = '1;
  logic busy_seen = 0;

  function automatic logic [7:0] resp(int k);
    return 8'(8'h30 + k);
  endfunction
  assign spi_miso = resp(nfall / 8)[7 - (nfall % 8)];

  always @(posedge spi_sclk) begin
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin cap[ncap] = sh; ncap++; bitc = 0; end
  end
  always @(negedge spi_sclk) nfall++;
  always @(negedge clk) begin
    for (int i = 0; i < NUM_CS; i++) begin
      if (prev_cs[i] && !spi_cs_n[i]) falls[i]++;
      if (!prev_cs[i] && spi_cs_n[i]) rises[i]++;
    end
    prev_cs = spi_cs_n;
    if (busy) busy_seen = 1;
  end

  function automatic logic [31:0] mk(logic [1:0] md, logic [7:0] opc, logic a4,
                                     logic dhi, logic [1:0] dlo, logic stop);
    return {8'h00, opc, 1'b0, dhi, a4, 5'b0, dlo, 3'b0, stop, md};
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clear_model();
    ncap = 0; nexp = 0; bitc = 0; nfall = 0; busy_seen = 0;
    for (int i = 0; i < NUM_CS; i++) begin falls[i] = 0; rises[i] = 0; end
  endtask

  task automatic push(logic [7:0] b);
    exb[nexp] = b; nexp++;
  endtask

  task automatic chk_frame(string rq);
    chk(rq, "byte count", 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(rq, $sformatf("byte %0d", i), 32'(cap[i]), 32'(exb[i]));
  endtask

  task automatic access(logic wr, logic cs, logic [31:0] a, logic [1:0] sz,
                        logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_write = wr; req_cs = cs; req_addr = a; req_size = sz; req_wdata = wd;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1", "cs_n", 32'(spi_cs_n), 32'(2'b11));
    chk("R1", "sclk", 32'(spi_sclk), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_read_basic();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd0, 8'h00, 1'b0, 1'b1, 2'b11, 1'b1);
    clear_model();
    access(0, 0, 32'h00123456, 2'd3, 0, rd, er);
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    for (int i = 0; i < 4; i++) push(8'h00);
    chk_frame("R2 R4");
    chk("R5", "rdata", rd, 32'h37363534);
    chk("R2", "err", 32'(er), 0);
    chk("R2", "cs falls", 32'(falls[0]), 1);
    chk("R2", "cs rises", 32'(rises[0]), 1);
    chk("R10", "busy seen", 32'(busy_seen), 1);
  endtask

  task automatic t_fast_4b();
    logic [31:0] rd; logic er;
    cfg_ctrl[63:32] = mk(2'd1, 8'h0C, 1'b1, 1'b0, 2'b01, 1'b1);
    clear_model();
    access(0, 1, 32'h00ABCDEF, 2'd1, 0, rd, er);
    push(8'h0C); push(8'h00); push(8'hAB); push(8'hCD); push(8'hEF);
    for (int i = 0; i < 8; i++) push(8'hA5);
    push(8'h00); push(8'h00);
    chk_frame("R3 R4");
    chk("R5", "rdata 2 bytes", rd, 32'h00003E3D);
    chk("R3", "cs1 falls", 32'(falls[1]), 1);
    chk("R3", "cs0 untouched", 32'(falls[0]), 0);
  endtask

  task automatic t_write_framed();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd2, 8'h02, 1'b0, 1'b0, 2'b00, 1'b1);
    cfg_wr_en = 2'b01;
    clear_model();
    access(1, 0, 32'h00000100, 2'd2, 32'hDDCCBBAA, rd, er);
    push(8'h02); push(8'h00); push(8'h01); push(8'h00);
    push(8'hAA); push(8'hBB); push(8'hCC);
    chk_frame("R6");
    chk("R6", "err", 32'(er), 0);
    chk("R6", "cs rises", 32'(rises[0]), 1);
  endtask

  task automatic t_user();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd3, 8'h9F, 1'b0, 1'b1, 2'b11, 1'b0);
    cfg_wr_en = 2'b01;
    #1;
    chk("R7", "cs_n follows stop=0", 32'(spi_cs_n[0]), 0);
    clear_model();
    access(1, 0, 32'h00FFFFF0, 2'd1, 32'h00001234, rd, er);
    push(8'h34); push(8'h12);
    chk_frame("R7 write");
    clear_model();
    access(0, 0, 32'h0, 2'd0, 0, rd, er);
    push(8'h00);
    chk_frame("R7 read");
    chk("R7", "rdata", rd, 32'h00000030);
    chk("R7", "no cs edge", 32'(falls[0] + rises[0]), 0);
    cfg_ctrl[31:0] = mk(2'd3, 8'h9F, 1'b0, 1'b0, 2'b00, 1'b1);
    #1;
    chk("R7", "cs_n follows stop=1", 32'(spi_cs_n[0]), 1);
  endtask

  task automatic t_drop();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd2, 8'h02, 1'b0, 1'b0, 2'b00, 1'b1);
    cfg_wr_en = 2'b00;
    clear_model();
    access(1, 0, 32'hFF000000, 2'd3, 32'h11223344, rd, er);
    chk("R8", "err", 32'(er), 1);
    chk("R8", "no bytes", 32'(ncap), 0);
    chk("R8", "no cs", 32'(falls[0]), 0);
  endtask

  task automatic t_segment();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd0, 8'h03, 1'b0, 1'b0, 2'b00, 1'b1);
    clear_model();
    access(0, 0, 32'h05123456, 2'd0, 0, rd, er);
    push(8'h03); push(8'h12); push(8'h34); push(8'h56); push(8'h00);
    chk_frame("R9");
    chk("R9", "err", 32'(er), 1);
    chk("R9", "rdata", rd, 32'h00000034);
  endtask

  task automatic t_read_in_write();
    logic [31:0] rd; logic er;
    cfg_ctrl[31:0] = mk(2'd2, 8'h02, 1'b0, 1'b0, 2'b00, 1'b1);
    clear_model();
    access(0, 0, 32'h10, 2'd3, 0, rd, er);
    chk("R11", "err", 32'(er), 1);
    chk("R11", "rdata", rd, 0);
    chk("R11", "no bytes", 32'(ncap), 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    int held;
    cfg_ctrl[31:0] = mk(2'd0, 8'h03, 1'b0, 1'b0, 2'b00, 1'b1);
    clear_model();
    @(negedge clk);
    req_write = 0; req_cs = 0; req_addr = 32'h000A0B0C; req_size = 0; req_valid = 1;
    @(negedge clk);
    req_addr = 32'h00010203;
    while (!rsp_valid) @(negedge clk);
    first = rsp_rdata;
    held = ncap;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10", "rsp held", 32'(rsp_valid), 1);
      chk("R10", "rdata stable", rsp_rdata, first);
      chk("R10", "no ready", 32'(req_ready), 0);
    end
    chk("R10", "no extra bytes", 32'(ncap), 32'(held));
    chk("R10", "first rdata", first, 32'h00000034);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R10", "ready back", 32'(req_ready), 1);
    clear_model();
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    push(8'h03); push(8'h01); push(8'h02); push(8'h03); push(8'h00);
    chk_frame("R10 second");
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cfg_ctrl = {mk(2'd0, 8'h03, 1'b0, 1'b0, 2'b00, 1'b1), mk(2'd0, 8'h03, 1'b0, 1'b0, 2'b00, 1'b1)};
    for (int i = 0; i < NUM_CS; i++) begin falls[i] = 0; rises[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_fast_4b();
    t_write_framed();
    t_user();
    t_drop();
    t_segment();
    t_read_in_write();
    t_backpressure();
    finish_run();
  end
endmodule